// File: doc/BRIEF.md
# Program Counter Breakpoint and Debug Trap Unit

This block sits next to a small processor core and gives a resident monitor routine a way to take control back from the main program. The core keeps running its unchanged code at full speed. The block watches the program counter and the retire strobe, and it raises a debug interrupt when one of three trap sources fires. The first source is an edge on an external halt pin, which event logic outside the chip can drive. The second is a comparator that matches the program counter against a stored address. The third is a single-step trap that fires once the main code has retired exactly one instruction.

One reserved register does two jobs. When an external halt occurs, it captures the program counter so the monitor can report where the program stopped. The monitor also writes a breakpoint address into it, and the comparator matches against that address. An enable bit gates the comparator, so a captured address does not trap again by itself. While the interrupt is being serviced, every trap source is masked. A return strobe from the monitor ends the service. A cause field records which source fired, and the monitor can read it.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset the debug interrupt is low. The reserved register, the control bits (breakpoint enable, step armed) and the cause field all read as zero.
- R2: A rising edge on `ext_halt` passes through a two-flop synchronizer and an edge detector. `dbg_irq` goes high after the third rising clock edge that follows the pin change. On that same edge the reserved register captures `pc`, the cause becomes 1, and the breakpoint enable is cleared.
- R3: One assertion of `ext_halt`, however long it is held, gives at most one trap. A pin that is still high after the monitor returns does not trap again.
- R4: A write with `wr_sel`=0 loads `wr_data` into the reserved register. A write with `wr_sel`=1 sets the breakpoint enable from `wr_data[0]` and the step-armed bit from `wr_data[1]`. Each write is visible on the next clock edge. A trap-driven update to the same state in the same cycle overrides the write.
- R5: When the breakpoint enable is set and `pc` equals the reserved register outside the monitor, `dbg_irq` rises on the next edge with cause 2. No trap occurs when the enable is clear or when the addresses differ.
- R6: When step is armed, the first cycle outside the monitor with `retire` high traps on the next edge with cause 3. Retires that happen inside the monitor do not count. Any trap clears the step-armed bit.
- R7: While `dbg_irq` is high, all three sources are masked, and the cause and the reserved register keep their values except for monitor writes. A `dbg_return` pulse drops `dbg_irq` on the next edge.
- R8: When several sources fire in the same cycle, the external halt wins over the breakpoint, and the breakpoint wins over single-step.
- R9: `rd_data` is a combinational read. `rd_sel`=0 returns the reserved register. `rd_sel`=1 returns {step armed, breakpoint enable} in bits 1:0. `rd_sel`=2 returns the cause in bits 1:0, coded 0 none, 1 external, 2 breakpoint, 3 step. `rd_sel`=3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | PC_W | Current program counter of the core |
| retire | input | 1 | One instruction retired this cycle |
| dbg_return | input | 1 | Monitor returns to the main code |
| ext_halt | input | 1 | Asynchronous external halt request |
| wr_en | input | 1 | Monitor register write strobe |
| wr_sel | input | 2 | Write target: 0 address register, 1 control bits |
| wr_data | input | PC_W | Write data |
| rd_sel | input | 2 | Read select |
| rd_data | output | PC_W | Read data |
| dbg_irq | output | 1 | Debug interrupt request, held while in the monitor |

## Verification
On every cycle the assertions check four things. A breakpoint match or an armed step retire outside the monitor must raise the interrupt on the next edge. The cause must stay frozen while the monitor runs. A return must drop the request, and the state must be consistent at entry: the enable is cleared after an external capture, and the step is disarmed after any trap. Only the bench scenarios can show the rest. These include the three-edge latency of the external pin, the single trap from a pin held high across a return, the value captured into the shared register, and the priority order when all three sources coincide.

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit #(
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc,
  input  logic            retire,
  input  logic            dbg_return,
  input  logic            ext_halt,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [PC_W-1:0] wr_data,
  input  logic [1:0]      rd_sel,
  output logic [PC_W-1:0] rd_data,
  output logic            dbg_irq
);

  localparam logic [1:0] CAUSE_EXT  = 2'd1;
  localparam logic [1:0] CAUSE_BP   = 2'd2;
  localparam logic [1:0] CAUSE_STEP = 2'd3;

  logic [2:0]      sync_q;
  logic [PC_W-1:0] dbg_reg;
  logic            bp_en;
  logic            step_armed;
  logic            in_mon;
  logic [1:0]      cause;

  logic ext_rise, bp_hit, step_hit, trap;

  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign bp_hit   = bp_en & (pc == dbg_reg);
  assign step_hit = step_armed & retire;
  assign trap     = ~in_mon & (ext_rise | bp_hit | step_hit);
  assign dbg_irq  = in_mon;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_halt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_reg    <= '0;
      bp_en      <= 1'b0;
      step_armed <= 1'b0;
      in_mon     <= 1'b0;
      cause      <= '0;
    end else begin
      if (wr_en && wr_sel == 2'd0) dbg_reg <= wr_data;
      if (wr_en && wr_sel == 2'd1) begin
        bp_en      <= wr_data[0];
        step_armed <= wr_data[1];
      end
      if (in_mon && dbg_return) in_mon <= 1'b0;
      if (trap) begin
        in_mon     <= 1'b1;
        step_armed <= 1'b0;
        if (ext_rise) begin
          cause   <= CAUSE_EXT;
          dbg_reg <= pc;
          bp_en   <= 1'b0;
        end else if (bp_hit) begin
          cause <= CAUSE_BP;
        end else begin
          cause <= CAUSE_STEP;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      2'd0: rd_data = dbg_reg;
      2'd1: rd_data[1:0] = {step_armed, bp_en};
      2'd2: rd_data[1:0] = cause;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dbg_trap_unit_chk.sv
module dbg_trap_unit_chk #(
  parameter int PC_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc,
  input logic            retire,
  input logic            dbg_return,
  input logic            dbg_irq,
  input logic [PC_W-1:0] addr_q,
  input logic            bp_en_q,
  input logic            step_q,
  input logic [1:0]      cause_q
);

  AST_BP_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_irq && bp_en_q && pc == addr_q) |=> dbg_irq); // R5

  AST_STEP_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_irq && step_q && retire) |=> dbg_irq); // R6

  AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |=> $stable(cause_q)); // R7

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_irq && !dbg_return) |=> dbg_irq); // R7

  AST_RETURN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_irq && dbg_return) |=> !dbg_irq); // R7

  AST_EXT_DISABLES_BP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dbg_irq) && cause_q == 2'd1) |-> !bp_en_q); // R2

  AST_TRAP_DISARMS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_irq) |-> !step_q); // R6

endmodule

bind dbg_trap_unit dbg_trap_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .retire(retire), .dbg_return(dbg_return),
  .dbg_irq(dbg_irq), .addr_q(dbg_reg), .bp_en_q(bp_en), .step_q(step_armed),
  .cause_q(cause)
);

// File: tb/dbg_trap_unit_test.sv
`timescale 1ns/1ps
module dbg_trap_unit_test;
  localparam int PC_W = 13;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] pc = '0, wr_data = '0, rd_data;
  logic retire = 0, dbg_return = 0, ext_halt = 0, wr_en = 0, dbg_irq;
  logic [1:0] wr_sel = '0, rd_sel = '0;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  dbg_trap_unit #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .retire(retire), .dbg_return(dbg_return),
    .ext_halt(ext_halt), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .dbg_irq(dbg_irq)
  );

  logic [PC_W-1:0] m_reg;
  logic m_bp, m_step, m_mon;
  logic [1:0] m_cause;

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] rd_exp(logic [1:0] s);
    logic [PC_W-1:0] v = '0;
    if (s == 2'd0) v = m_reg;
    else if (s == 2'd1) v[1:0] = {m_step, m_bp};
    else if (s == 2'd2) v[1:0] = m_cause;
    return v;
  endfunction

  task automatic model_step();
    logic bp, st, tr;
    bp = m_bp && (pc == m_reg);
    st = m_step && retire;
    tr = !m_mon && (bp || st);
    if (wr_en && wr_sel == 2'd0) m_reg = wr_data;
    if (wr_en && wr_sel == 2'd1) begin m_bp = wr_data[0]; m_step = wr_data[1]; end
    if (m_mon && dbg_return) m_mon = 1'b0;
    if (tr) begin
      m_mon = 1'b1; m_step = 1'b0;
      m_cause = bp ? 2'd2 : 2'd3;
    end
  endtask

  task automatic wr(logic [1:0] s, logic [PC_W-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; cyc(); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [PC_W-1:0] v);
    rd_sel = s; #0.5; v = rd_data;
  endtask

  task automatic do_return();
    dbg_return = 1; cyc(); dbg_return = 0;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] v;
    void'($urandom(32'h5eed_0d1b));
    cyc(); cyc();
    rst_n = 1; cyc();

    chk("R1 irq", dbg_irq, 0);
    rd(0, v); chk("R1 reg", v, 0);
    rd(1, v); chk("R1 ctl", v, 0);
    rd(2, v); chk("R1 cause", v, 0);

    wr(0, 13'h123);
    rd(0, v); chk("R4 addr write", v, 13'h123);
    rd(3, v); chk("R9 sel3 zero", v, 0);
    pc = 13'h123; cyc(); cyc();
    chk("R5 disabled no trap", dbg_irq, 0);

    pc = 13'h050;
    wr(1, 13'h1);
    rd(1, v); chk("R4 ctl write", v, 1);
    chk("R5 mismatch no trap", dbg_irq, 0);
    pc = 13'h123; cyc();
    chk("R5 match traps", dbg_irq, 1);
    rd(2, v); chk("R5 cause", v, 2);

    retire = 1; ext_halt = 1;
    repeat (5) cyc();
    ext_halt = 0; retire = 0;
    repeat (4) cyc();
    chk("R7 irq held", dbg_irq, 1);
    rd(2, v); chk("R7 cause frozen", v, 2);
    rd(0, v); chk("R7 reg not captured", v, 13'h123);
    wr(1, 13'h0);
    do_return();
    chk("R7 return clears", dbg_irq, 0);

    pc = 13'h0AA; wr(1, 13'h1); pc = 13'h0AB;
    ext_halt = 1;
    cyc(); chk("R2 latency edge1", dbg_irq, 0);
    cyc(); chk("R2 latency edge2", dbg_irq, 0);
    cyc(); chk("R2 latency edge3", dbg_irq, 1);
    rd(0, v); chk("R2 pc captured", v, 13'h0AB);
    rd(2, v); chk("R2 cause", v, 1);
    rd(1, v); chk("R2 bp disabled", v, 0);

    wr(1, 13'h2);
    retire = 1; cyc(); cyc(); retire = 0;
    chk("R6 monitor retires ignored", dbg_irq, 1);
    do_return();
    chk("R3 return", dbg_irq, 0);
    repeat (4) cyc();
    chk("R3 held pin no retrap", dbg_irq, 0);
    retire = 1; cyc(); retire = 0;
    chk("R6 step traps", dbg_irq, 1);
    rd(2, v); chk("R6 cause", v, 3);
    rd(1, v); chk("R6 disarmed", v, 0);
    ext_halt = 0; repeat (4) cyc();

    wr(0, 13'h300); wr(1, 13'h3); pc = 13'h100;
    do_return();
    ext_halt = 1; cyc(); cyc();
    pc = 13'h300; retire = 1; cyc(); retire = 0;
    chk("R8 ext wins irq", dbg_irq, 1);
    rd(2, v); chk("R8 ext wins cause", v, 1);
    rd(1, v); chk("R8 ext clears ctl", v, 0);
    ext_halt = 0; repeat (4) cyc();

    wr(0, 13'h310); wr(1, 13'h3); pc = 13'h100;
    do_return();
    pc = 13'h310; retire = 1; cyc(); retire = 0;
    rd(2, v); chk("R8 bp over step", v, 2);
    rd(1, v); chk("R8 step disarmed", v, 1);

    rst_n = 0; cyc(); rst_n = 1; pc = '0;
    chk("R1 re-reset irq", dbg_irq, 0);
    m_reg = '0; m_bp = 0; m_step = 0; m_mon = 0; m_cause = '0;
    for (int i = 0; i < 3000; i++) begin
      pc = ($urandom % 2) ? m_reg : PC_W'($urandom % 8);
      retire = ($urandom % 3) == 0;
      dbg_return = ($urandom % 4) == 0;
      wr_en = ($urandom % 4) == 0;
      wr_sel = 2'($urandom % 2);
      wr_data = PC_W'($urandom % 8);
      rd_sel = 2'($urandom % 4);
      model_step();
      cyc();
      chk("R5/R6/R7 random irq", dbg_irq, m_mon);
      chk("R4/R9 random read", rd_data, rd_exp(rd_sel));
    end
    wr_en = 0; dbg_return = 0; retire = 0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule